// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause-22 management transactions on an MDC clock pin and a tri-stated MDIO data pin. Software loads one 32-bit word into the command register. That word holds the start code, the opcode, the PHY and register addresses, the turnaround code and the data. Each word starts one transaction. The block first sends a preamble of 32 ones and then shifts the word out MSB first. On a read, it samples the line during the data bits. At the end it writes the 16 returned bits into the low half of the command register and sets a sticky done flag. Software clears that flag by writing a one to it.

The MDC rate comes from a 6-bit divisor in the rate register. Each half of the MDC period lasts that many system clocks. A divisor of zero stops the clock, so no transaction can start. The controller is built around one state machine with three states. `ST_IDLE` waits for a command. `ST_LOW` holds MDC low and presents the current bit. `ST_HIGH` holds MDC high.

The transitions are:
- `ST_IDLE` to `ST_LOW` when a command word is written and the divisor is not zero.
- `ST_LOW` to `ST_HIGH` when the half-period timer expires. The line is sampled at this edge.
- `ST_HIGH` to `ST_LOW` when the timer expires and more bits remain. The next bit is presented at this edge.
- `ST_HIGH` to `ST_IDLE` when the timer expires on the last bit. The done flag is set at this edge.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, every register reads zero (command, done flag, divisor, busy). MDC, MDIO output and MDIO enable are all low.
- R2: A command write (reg_addr 0) with a nonzero divisor S makes busy (bit 0 at reg_addr 3) read 1 from the next cycle, for exactly 128·S cycles. It then reads 0, and the done flag (bit 0 at reg_addr 1) reads 1.
- R3: During a transaction, MDC is low for S cycles and then high for S cycles, for every bit. S is captured when the transaction starts, so rewriting the divisor mid-transaction has no effect on it.
- R4: The serial stream is 32 ones followed by command bits 31 down to 0. The output bit changes only together with a falling MDC edge. The output reads 0 while idle.
- R5: A command whose bits 29:28 equal 2'b10 is a read. For a read, the MDIO enable is high for the first 46 bits and low for the last 18. For any other opcode the enable is high for all 64 bits. The enable is low while idle.
- R6: During a read, MDIO input is sampled at each MDC rising edge. At completion, command bits 15:0 hold the last 16 samples, first sample in bit 15. Bits 31:16 are unchanged.
- R7: On a read where no device drives the line (the input held high), the result is 16'hFFFF.
- R8: Writing reg_addr 1 with bit 0 set clears the done flag. Writing it with bit 0 clear leaves the flag unchanged.
- R9: A command write while busy is ignored. The command register and the transaction in flight are unaffected.
- R10: The divisor is at reg_addr 2, bits 6:1. With a divisor of 0, a command write is stored but starts nothing: busy and MDC stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 done flag, 2 divisor, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO line value (pulled high externally) |

## Verification
The hardest situation to reach is a register write that lands in the middle of a transaction. Two kinds of write matter here: a second command, which must be ignored, and a new divisor, which must not change the running clock. The bench injects both at fixed cycles inside a running transaction. It does this from the same loop that compares every cycle against its bit-level model. The model's timing stays tied to the divisor captured at the start, so any leak of the new divisor or command shows up at once as a clock or data mismatch. Read data is returned by a behavioural PHY that drives the line only while the enable is released.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
    localparam int FRAME_W = 32;
    localparam int PRE_W   = 32;
    localparam int SPD_W   = 6;
    localparam int DATA_W  = 16;
    localparam int TOT_W   = PRE_W + FRAME_W;
    localparam int IDX_W   = $clog2(TOT_W);
    localparam int TA_POS  = PRE_W + 14;   // first turnaround bit in the stream

    localparam logic [1:0] OP_READ     = 2'b10;
    localparam logic [1:0] ADDR_FRAME  = 2'd0;
    localparam logic [1:0] ADDR_EVENT  = 2'd1;
    localparam logic [1:0] ADDR_SPEED  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } mdio_state_e;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SPD_W-1:0] half_in,
    output logic             tick
);
    logic [SPD_W-1:0] half_q;
    logic [SPD_W-1:0] cnt_q;

    assign tick = run && (cnt_q == half_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            half_q <= half_in;
            cnt_q  <= '0;
        end else if (tick) begin
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_bit_shifter.sv
module mdio_bit_shifter #(
    parameter int FRAME_W = 32,
    parameter int PRE_W   = 32,
    parameter int DATA_W  = 16,
    localparam int TOT_W  = PRE_W + FRAME_W,
    localparam int IDX_W  = $clog2(TOT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic              shift,
    input  logic              sample,
    input  logic              mdi,
    output logic              mdo,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              last,
    output logic [DATA_W-1:0] rd_data
);
    logic [TOT_W-1:0] sr_q;

    assign mdo  = sr_q[TOT_W-1];
    assign last = (bit_idx == IDX_W'(TOT_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            bit_idx <= '0;
        end else if (load) begin
            sr_q    <= {{PRE_W{1'b1}}, frame_in};
            bit_idx <= '0;
        end else if (shift) begin
            sr_q    <= {sr_q[TOT_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (sample) rd_data <= {rd_data[DATA_W-2:0], mdi};
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_state_e       state_q, state_d;
    logic [FRAME_W-1:0] frame_q;
    logic [SPD_W-1:0]  speed_q;
    logic              evt_q;
    logic              is_rd_q;
    logic              wr_frame, wr_event, wr_speed, start;
    logic              tick, sample, shift, done, busy, mdo, last;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rd_data;

    assign wr_frame = reg_wr_en && (reg_addr == ADDR_FRAME);
    assign wr_event = reg_wr_en && (reg_addr == ADDR_EVENT);
    assign wr_speed = reg_wr_en && (reg_addr == ADDR_SPEED);
    assign start    = wr_frame && (state_q == ST_IDLE) && (speed_q != '0);

    mdio_half_timer #(.SPD_W(SPD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(start), .run(busy),
        .half_in(speed_q), .tick(tick)
    );

    mdio_bit_shifter #(.FRAME_W(FRAME_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .frame_in(reg_wdata),
        .shift(shift), .sample(sample), .mdi(mdio_i), .mdo(mdo),
        .bit_idx(bit_idx), .last(last), .rd_data(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = last ? ST_IDLE : ST_LOW;
            default:            state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy   = 1'b0;
        mdc    = 1'b0;
        sample = 1'b0;
        shift  = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOW: begin
                busy   = 1'b1;
                sample = tick;
            end
            ST_HIGH: begin
                busy  = 1'b1;
                mdc   = 1'b1;
                shift = tick && !last;
                done  = tick && last;
            end
            default: ;
        endcase
    end

    assign mdio_o  = busy && mdo;
    assign mdio_oe = busy && (!is_rd_q || (bit_idx < IDX_W'(TA_POS)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            speed_q <= '0;
            evt_q   <= 1'b0;
            is_rd_q <= 1'b0;
        end else begin
            if (wr_frame && !busy)
                frame_q <= reg_wdata;
            else if (done && is_rd_q)
                frame_q[DATA_W-1:0] <= rd_data;
            if (start)
                is_rd_q <= (reg_wdata[29:28] == OP_READ);
            if (wr_speed)
                speed_q <= reg_wdata[SPD_W:1];
            if (done)
                evt_q <= 1'b1;
            else if (wr_event && reg_wdata[0])
                evt_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_FRAME:  reg_rdata = frame_q;
            ADDR_EVENT:  reg_rdata = {31'd0, evt_q};
            ADDR_SPEED:  reg_rdata = {{(31-SPD_W){1'b0}}, speed_q, 1'b0};
            ADDR_STATUS: reg_rdata = {31'd0, busy};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk
    import mdio_frame_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               mdc,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               evt,
    input logic               done,
    input logic               wr_frame,
    input logic [FRAME_W-1:0] frame_q,
    input logic [SPD_W-1:0]   speed_q
);
    // R1 / R5: pins quiet while idle
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe && !mdio_o));

    // R4: data changes only together with a falling MDC
    assert_mdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    // R2: completion raises the flag
    assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> evt);

    // R9: command writes while busy leave the register alone
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_frame && !done) |=> $stable(frame_q));

    // R10: a zero divisor never starts a transaction
    assert_zero_speed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && speed_q == '0) |=> !busy);
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .evt(evt_q), .done(done), .wr_frame(wr_frame),
    .frame_q(frame_q), .speed_q(speed_q)
);

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    mdio_frame_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // behavioural model: bit b occupies cycles [2S*b, 2S*b+2S) after the write edge
    task automatic run_txn(input int s, input logic [31:0] cmd, input bit phy,
                           input logic [15:0] pdat, input bit poke_busy, input bit poke_speed);
        bit   is_rd;
        int   b;
        logic exp_bit, exp_oe;
        logic [31:0] rd;
        is_rd = (cmd[29:28] == 2'b10);
        reg_write(2'd0, cmd);
        for (int k = 0; k < 128 * s; k++) begin
            @(negedge clk);
            reg_wr_en = 1'b0;
            reg_addr  = 2'd3;
            b = k / (2 * s);
            mdio_i = (phy && is_rd && b >= 48) ? pdat[63 - b] : 1'b1;
            #1;
            exp_bit = (b < 32) ? 1'b1 : cmd[63 - b];
            exp_oe  = is_rd ? (b < 46) : 1'b1;
            chk(mdc == 1'((k / s) % 2), "R3 mdc", {31'd0, mdc}, (k / s) % 2);
            chk(mdio_o == exp_bit, "R4 mdo", {31'd0, mdio_o}, {31'd0, exp_bit});
            chk(mdio_oe == exp_oe, "R5 oe", {31'd0, mdio_oe}, {31'd0, exp_oe});
            chk(reg_rdata[0] == 1'b1, "R2 busy", reg_rdata, 32'd1);
            if (poke_speed && k == 5) begin
                reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd1 << 1;
            end
            if (poke_busy && k == 10) begin
                reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hDEAD_BEEF;
            end
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
        mdio_i = 1'b1;
        reg_addr = 2'd3;
        #1;
        chk(reg_rdata[0] == 1'b0, "R2 busy end", reg_rdata, 32'd0);
        chk(!mdc && !mdio_oe && !mdio_o, "R5 idle pins", {29'd0, mdc, mdio_oe, mdio_o}, 32'd0);
        reg_read(2'd1, rd);
        chk(rd == 32'd1, "R2 done flag", rd, 32'd1);
    endtask

    initial begin
        logic [31:0] rd, cmd;
        repeat (3) @(negedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1 chk(reg_rdata == 32'd0, "R1 reset reg", reg_rdata, 32'd0);
        end
        chk(!mdc && !mdio_o && !mdio_oe, "R1 pins", {29'd0, mdc, mdio_o, mdio_oe}, 32'd0);
        rst_n = 1'b1;

        // R10: zero divisor stores but does not start
        reg_write(2'd0, 32'h6082_0000);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            reg_addr = 2'd3;
            #1 chk(reg_rdata[0] == 1'b0 && !mdc, "R10 no start", {30'd0, mdc, reg_rdata[0]}, 32'd0);
        end
        reg_read(2'd0, rd);
        chk(rd == 32'h6082_0000, "R10 stored", rd, 32'h6082_0000);

        // R6: read with PHY present, divisor 2
        reg_write(2'd2, 32'd2 << 1);
        reg_read(2'd2, rd);
        chk(rd == 32'd4, "R10 divisor field", rd, 32'd4);
        cmd = 32'h6002_0000 | (32'd5 << 23) | (32'd2 << 18);
        run_txn(2, cmd, 1'b1, 16'hA5C3, 1'b0, 1'b0);
        reg_read(2'd0, rd);
        chk(rd == ((cmd & 32'hFFFF_0000) | 32'hA5C3), "R6 read data", rd, (cmd & 32'hFFFF_0000) | 32'hA5C3);

        // R8: write-one-to-clear
        reg_write(2'd1, 32'd0);
        reg_read(2'd1, rd);
        chk(rd == 32'd1, "R8 zero keeps", rd, 32'd1);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, rd);
        chk(rd == 32'd0, "R8 one clears", rd, 32'd0);

        // R9 + R3 latching: write command, divisor 3, pokes mid-flight
        reg_write(2'd2, 32'd3 << 1);
        cmd = 32'h5002_0000 | (32'd17 << 23) | (32'd9 << 18) | 32'h1234;
        run_txn(3, cmd, 1'b0, 16'h0000, 1'b1, 1'b1);
        reg_read(2'd0, rd);
        chk(rd == cmd, "R9 ignored write", rd, cmd);
        reg_read(2'd2, rd);
        chk(rd == 32'd2, "R3 divisor updated after", rd, 32'd2);
        reg_write(2'd1, 32'd1);

        // R7: read with nobody driving, divisor 1
        cmd = 32'h6002_0000 | (32'd31 << 23) | (32'd1 << 18) | 32'h0042;
        run_txn(1, cmd, 1'b0, 16'h0000, 1'b0, 1'b0);
        reg_read(2'd0, rd);
        chk(rd == ((cmd & 32'hFFFF_0000) | 32'hFFFF), "R7 float", rd, (cmd & 32'hFFFF_0000) | 32'hFFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule